// File: doc/BRIEF.md
# Nibble Memory Immediate Store Unit

This unit carries out one instruction of a core with a 4-bit data path. The instruction takes an 8-bit constant and puts it into two neighbouring 4-bit data-memory cells. It then moves the index pointer X forward by two. The unit keeps X, an 8-bit register, and drives a nibble-wide write port made of an address, a 4-bit data bus and a write enable.

The surrounding core presents a 12-bit opcode together with a start strobe. If the top four bits match the store pattern, the unit runs a fixed five-cycle sequence:

- It writes the low nibble of the constant to the cell that X points to.
- On a later cycle, it writes the high nibble to the cell after it.
- It raises a one-cycle done pulse and steps X.

The unit has no status-flag outputs, so a wrap of X leaves every flag of the core untouched. The core may also load X directly through a separate load port while the unit is idle.

Top module: `nib_store_unit`

## Requirements
- R1: After reset, xOut is 8'h00, and busy, done and memWe are all 0.
- R2: An instruction is accepted on a rising edge where start is 1, busy is 0 and opcode[11:8] equals 4'b1001. Any other value in opcode[11:8] causes no write, no done pulse, no busy and no change of X.
- R3: Counting the cycle after the accepting edge as cycle 1, memWe is 1 in cycle 2 with memAddr equal to X and memWdata equal to opcode[3:0].
- R4: In cycle 3, memWe is 1 with memAddr equal to (X+1) mod 256 and memWdata equal to opcode[7:4].
- R5: Each instruction makes exactly two write-enable pulses, the low-nibble one first. memWe is 0 in cycles 1, 4 and 5.
- R6: busy is 1 in cycles 1 through 5. done is 1 in cycle 5 only, so the instruction takes five cycles.
- R7: At the edge that ends cycle 5, X becomes (X+2) mod 256. Wrap-around from 8'hFE or 8'hFF is silent.
- R8: A start given while busy is 1 is ignored, whatever the opcode.
- R9: While busy is 0, xLoad at a rising edge sets X to xIn. While busy is 1, xLoad is ignored.
- R10: Starting from X = 8'h1E, storing 8'h18 and then 8'h36 leaves the cells 1E..21 holding 8, 1, 6, 3, and leaves X at 8'h22.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction present on opcode |
| opcode | input | 12 | Instruction word: pattern in [11:8], constant in [7:0] |
| xLoad | input | 1 | Load X from xIn (idle only) |
| xIn | input | 8 | Value for an X load |
| memAddr | output | 8 | Data-memory write address |
| memWdata | output | 4 | Data-memory write nibble |
| memWe | output | 1 | Data-memory write enable |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Final cycle of the instruction |
| xOut | output | 8 | Current value of X |

## Verification
The hardest situation to reach from the ports is the pointer crossing 8'hFF. In that case the high-nibble address and the stepped X must both wrap to the bottom of memory, and nothing else may react. The bench loads X with 8'hFE and with 8'hFF through the load port before storing. Random loads also land near the top.

The bench also holds start and xLoad high all through an instruction, with random opcodes and values. This shows that nothing presented mid-sequence alters the cells or X.

// File: rtl/nib_store_pkg.sv
package nib_store_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic latchImm;  // capture constant on accept
    logic weLo;      // low-nibble write cycle
    logic weHi;      // high-nibble write cycle
    logic bumpX;     // final cycle: advance pointer
  } strb_t;
endpackage

// File: rtl/nib_store_ctrl.sv
module nib_store_ctrl
  import nib_store_pkg::*;
#(
  parameter int OP_W     = 12,
  parameter int PAT_W    = 4,
  parameter logic [PAT_W-1:0] PATTERN = 4'b1001,
  parameter int CYCLES   = 5,
  parameter int LO_PHASE = 2,
  parameter int HI_PHASE = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [OP_W-1:0] opcode,
  output strb_t           strb,
  output logic            busy,
  output logic            done
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES);
  localparam logic [CNT_W-1:0] LOP  = CNT_W'(LO_PHASE);
  localparam logic [CNT_W-1:0] HIP  = CNT_W'(HI_PHASE);

  logic [CNT_W-1:0] phase;
  logic accept;

  assign accept = start && (phase == '0) && (opcode[OP_W-1 -: PAT_W] == PATTERN);

  always_ff @(posedge clk) begin
    if (!rstN)                phase <= '0;
    else if (accept)          phase <= CNT_W'(1);
    else if (phase == LAST)   phase <= '0;
    else if (phase != '0)     phase <= phase + CNT_W'(1);
  end

  always_comb begin
    strb          = '0;
    strb.latchImm = accept;
    strb.weLo     = (phase == LOP);
    strb.weHi     = (phase == HIP);
    strb.bumpX    = (phase == LAST);
  end

  assign busy = (phase != '0);
  assign done = strb.bumpX;

  // R5: never both write strobes at once
  a_r5_one_write: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.weLo, strb.weHi}));
  // R5: high write directly follows low write
  a_r5_lo_then_hi: assert property (@(posedge clk) disable iff (!rstN)
    strb.weLo |=> strb.weHi);
  // R8: start while busy does not restart the sequence
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> (busy && phase != CNT_W'(1)));
  // R6: done ends the busy period
  a_r6_done_ends: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

// File: rtl/nib_store_dp.sv
module nib_store_dp
  import nib_store_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NIB_W  = 4,
  parameter int STEP   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  strb_t               strb,
  input  logic                busy,
  input  logic [2*NIB_W-1:0]  immIn,
  input  logic                xLoad,
  input  logic [ADDR_W-1:0]   xIn,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [NIB_W-1:0]    memWdata,
  output logic                memWe,
  output logic [ADDR_W-1:0]   xOut
);
  localparam logic [ADDR_W-1:0] INC = ADDR_W'(STEP);

  logic [ADDR_W-1:0]  xReg;
  logic [2*NIB_W-1:0] immReg;

  always_ff @(posedge clk) begin
    if (!rstN)              xReg <= '0;
    else if (strb.bumpX)    xReg <= xReg + INC;
    else if (xLoad && !busy) xReg <= xIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              immReg <= '0;
    else if (strb.latchImm) immReg <= immIn;
  end

  assign memAddr  = strb.weHi ? xReg + ADDR_W'(1) : xReg;
  assign memWdata = strb.weHi ? immReg[2*NIB_W-1:NIB_W] : immReg[NIB_W-1:0];
  assign memWe    = strb.weLo | strb.weHi;
  assign xOut     = xReg;

  // R4: high write goes to the cell after the low write
  a_r4_next_cell: assert property (@(posedge clk) disable iff (!rstN)
    strb.weHi |-> (memWe && memAddr == $past(memAddr) + ADDR_W'(1)));
  // R7: pointer advances by the step, modulo the address width
  a_r7_step: assert property (@(posedge clk) disable iff (!rstN)
    strb.bumpX |=> (xOut == $past(xOut) + INC));
  // R9: pointer frozen during the sequence before the final cycle
  a_r9_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.bumpX) |=> $stable(xOut));
endmodule

// File: rtl/nib_store_unit.sv
module nib_store_unit
  import nib_store_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NIB_W  = 4,
  parameter int OP_W   = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [OP_W-1:0]   opcode,
  input  logic              xLoad,
  input  logic [ADDR_W-1:0] xIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [NIB_W-1:0]  memWdata,
  output logic              memWe,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] xOut
);
  strb_t strb;

  nib_store_ctrl #(.OP_W(OP_W), .PAT_W(OP_W - 2*NIB_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode),
    .strb(strb), .busy(busy), .done(done)
  );

  nib_store_dp #(.ADDR_W(ADDR_W), .NIB_W(NIB_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy),
    .immIn(opcode[2*NIB_W-1:0]), .xLoad(xLoad), .xIn(xIn),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe), .xOut(xOut)
  );

  // R6: done only while busy
  a_r6_done_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);
endmodule

// File: tb/sim_nib_store_unit.sv
module sim_nib_store_unit;
  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, xLoad = 1'b0;
  logic [11:0] opcode = '0;
  logic [7:0] xIn = '0, memAddr, xOut;
  logic [3:0] memWdata;
  logic memWe, busy, done;

  int nChk = 0, nFail = 0;
  logic [7:0] xModel = '0;
  logic [3:0] ram [256];
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  nib_store_unit u0 (.clk(clk), .rstN(rstN), .start(start), .opcode(opcode),
    .xLoad(xLoad), .xIn(xIn), .memAddr(memAddr), .memWdata(memWdata),
    .memWe(memWe), .busy(busy), .done(done), .xOut(xOut));

  always @(posedge clk) if (memWe) ram[memAddr] <= memWdata;

  task automatic check(string req, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] wrapAdd(logic [7:0] a, int k);
    return 8'(int'(a) + k);
  endfunction

  task automatic loadX(logic [7:0] v);
    @(negedge clk); xLoad = 1; xIn = v;
    @(negedge clk); xLoad = 0;
    xModel = v;
    check("R9 load", xOut, v);
  endtask

  task automatic store(logic [7:0] imm, bit poke);
    logic [7:0] x0 = xModel;
    @(negedge clk); start = 1; opcode = {4'b1001, imm};
    @(negedge clk);                                   // cycle 1
    start = poke; opcode = {4'($urandom), 8'($urandom)};
    xLoad = poke; xIn = 8'($urandom);
    check("R6 busy c1", busy, 1); check("R5 we c1", memWe, 0);
    @(negedge clk);                                   // cycle 2
    check("R3 we", memWe, 1); check("R3 addr", memAddr, x0);
    check("R3 data", memWdata, imm[3:0]);
    @(negedge clk);                                   // cycle 3
    check("R4 we", memWe, 1); check("R4 addr", memAddr, wrapAdd(x0, 1));
    check("R4 data", memWdata, imm[7:4]);
    @(negedge clk);                                   // cycle 4
    check("R5 we c4", memWe, 0); check("R6 done c4", done, 0);
    @(negedge clk);                                   // cycle 5
    check("R6 done c5", done, 1); check("R5 we c5", memWe, 0);
    check("R9 x held", xOut, x0);
    @(negedge clk);
    start = 0; xLoad = 0;
    xModel = wrapAdd(x0, 2);
    check("R7 x step", xOut, xModel); check("R6 idle", busy, 0);
    check("R8 no redo", memWe, 0);
    check("R3 ram lo", ram[x0], imm[3:0]);
    check("R4 ram hi", ram[wrapAdd(x0, 1)], imm[7:4]);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFail++; nChk++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    foreach (ram[i]) ram[i] = 4'h0;
    repeat (3) @(negedge clk);
    check("R1 x", xOut, 0); check("R1 busy", busy, 0);
    check("R1 done", done, 0); check("R1 we", memWe, 0);
    rstN = 1;
    // R10 worked example
    loadX(8'h1E); ram[8'h1F] = 4'hF; ram[8'h21] = 4'h7;
    store(8'h18, 0); store(8'h36, 0);
    check("R10 1E", ram[8'h1E], 8); check("R10 1F", ram[8'h1F], 1);
    check("R10 20", ram[8'h20], 6); check("R10 21", ram[8'h21], 3);
    check("R10 x", xOut, 8'h22);
    // R2 non-matching patterns
    for (int k = 0; k < 16; k++) begin
      if (k == 9) continue;
      @(negedge clk); start = 1; opcode = {4'(k), 8'($urandom)};
      @(negedge clk); start = 0;
      check("R2 busy", busy, 0);
      repeat (5) begin
        @(negedge clk);
        check("R2 we", memWe, 0); check("R2 done", done, 0);
      end
      check("R2 x", xOut, xModel);
    end
    // R7 wrap corners
    loadX(8'hFF); store(8'hA5, 1);
    loadX(8'hFE); store(8'h3C, 0);
    // R8/R9 poke and random mix
    for (int n = 0; n < 200; n++) begin
      if ($urandom_range(0, 3) == 0) loadX(8'($urandom));
      store(8'($urandom), bit'($urandom_range(0, 1)));
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule